// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Controller

This block sits between a host-side I/O read/write interface and an enhanced parallel port connector. When the host reads or writes one of the two EPP registers (address or data), the controller runs an interlocked handshake with the peripheral. It uses a direction line, a data strobe, an address strobe and the peripheral's active-low wait line. While the peripheral has not answered, it holds the host's ready line low so that the host cycle stretches.

A watchdog counts the cycles the handshake spends waiting. It is sized from the clock frequency and a timeout in microseconds. When it expires, the controller ends the handshake, lets the host finish and records the event in bit 0 of a status register. Reading the status register clears that bit.

Outside an EPP cycle the connector behaves as a plain or bidirectional printer port. The shared control pins, the data pins and the pin direction follow a control register and a data latch that the host writes. The host strobes are asynchronous and pass through synchronisers before use, so the first reaction to a host strobe comes three clock edges after it. Tri-state pins are modelled as a data output plus an output enable.

Top module: `epp_cycle_ctrl`

## Requirements
- R1: After reset, host_rdy is 1 and the status timeout bit is 0. With the control register at 0, pp_stb_n, pp_afd_n, pp_slin_n and pp_init_n are 1, pd_oe is 1 and pd_out is 0.
- R2: A host read or write with host_sel 3 (EPP address) or 4 (EPP data) pulls host_rdy low until the handshake ends. Accesses to the other selects never pull host_rdy low.
- R3: While pp_wait_n is high, no EPP strobe (pp_afd_n or pp_slin_n) is asserted and the direction line is not changed.
- R4: In an EPP read, pd_oe is 0 and pp_stb_n is 1 while the strobe is low. The strobe is pp_slin_n for select 3 and pp_afd_n for select 4. When pp_wait_n rises, pd_in is captured into host_rdata, the strobe returns high and host_rdy rises.
- R5: In an EPP write, pp_stb_n is 0, pd_oe is 1 and pd_out carries host_wdata while the matching strobe is low. host_rdy rises once pp_wait_n is high. The strobe stays low until the host releases host_wr_n.
- R6: If the handshake waits CLK_KHZ*TMO_US/1000 cycles without finishing, the cycle aborts. host_rdy rises, both EPP strobes go high, status bit 0 is set, and an aborted read returns 8'hFF.
- R7: A host read of select 1 (status) returns the timeout flag in bit 0 with the other bits 0, and clears the flag.
- R8: Outside EPP cycles, pp_stb_n = ~ctrl[0], pp_afd_n = ~ctrl[1], pp_init_n = ~ctrl[2], pp_slin_n = ~ctrl[3] and pd_oe = ~ctrl[5]. The control register is written and read at select 2.
- R9: A write to select 0 loads the data latch driven on pd_out. A read of select 0 returns pd_in when ctrl[5] is 1, and the latch otherwise.
- R10: Reads and writes with host_sel 5, 6 or 7 change no register and no pin. Reads with these selects return 0.
- R11: If the peripheral's pp_wait_n rise and the watchdog expiry are seen in the same cycle, the cycle completes normally. Every cycle ends either as a completion (flag clear, data returned) or as an abort (flag set, 8'hFF), never as a mix of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_sel | input | 3 | Register select (0 data, 1 status, 2 control, 3 EPP address, 4 EPP data) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data |
| host_rdy | output | 1 | Host ready, low stretches the host cycle |
| pd_in | input | 8 | Data pins as seen from the connector |
| pd_out | output | 8 | Data pin drive value |
| pd_oe | output | 1 | Data pin output enable |
| pp_wait_n | input | 1 | Peripheral wait, low means ready for a strobe |
| pp_stb_n | output | 1 | Strobe pin, write-direction line during EPP cycles |
| pp_afd_n | output | 1 | Auto-feed pin, data strobe during EPP cycles |
| pp_slin_n | output | 1 | Select-in pin, address strobe during EPP cycles |
| pp_init_n | output | 1 | Initialise pin |

## Verification
The peripheral's completion edge and the watchdog expiry can land in the same cycle, and the controller must then pick exactly one outcome. The bench sweeps the peripheral's response delay one cycle at a time across the window around the timeout limit. At each step it checks that the result is either a clean completion (flag clear, the driven byte returned) or a clean abort (flag set, 8'hFF). It also checks that both outcomes occur across the sweep.

// File: rtl/epp_pkg.sv
package epp_pkg;

    localparam int DW = 8;

    localparam logic [2:0] SEL_DATA  = 3'd0;
    localparam logic [2:0] SEL_STAT  = 3'd1;
    localparam logic [2:0] SEL_CTRL  = 3'd2;
    localparam logic [2:0] SEL_EADDR = 3'd3;
    localparam logic [2:0] SEL_EDATA = 3'd4;

    localparam int CB_STB  = 0;
    localparam int CB_AFD  = 1;
    localparam int CB_INIT = 2;
    localparam int CB_SLIN = 3;
    localparam int CB_DIR  = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_READY,
        S_STROBE,
        S_WAIT_DATA,
        S_TERMINATE,
        S_ABORT
    } epp_state_e;

    typedef struct packed {
        epp_state_e    st;
        logic          is_rd;
        logic          is_adr;
        logic          rd_p;
        logic          wr_p;
        logic [DW-1:0] data;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] rdata;
        logic [DW-1:0] eout;
        logic          rdy;
        logic          tmo;
    } core_regs_t;

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int           N       = 3,
    parameter int           STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= RST_VAL;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/epp_wdog.sv
module epp_wdog #(
    parameter int LIMIT = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)              cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/epp_core.sv
module epp_core
    import epp_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic          wait_s,
    input  logic [2:0]    sel,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pd_in,
    input  logic          expired,
    output logic          run,
    output logic [DW-1:0] rdata,
    output logic          rdy,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          stb_n,
    output logic          afd_n,
    output logic          slin_n,
    output logic          init_n
);

    core_regs_t r_d, r_q;
    logic rd_rise, wr_rise, host_act;

    assign rd_rise  = rd_s && !r_q.rd_p;
    assign wr_rise  = wr_s && !r_q.wr_p;
    assign host_act = r_q.is_rd ? rd_s : wr_s;
    assign run      = (r_q.st == S_WAIT_READY) || (r_q.st == S_STROBE) ||
                      (r_q.st == S_WAIT_DATA);

    always_comb begin
        r_d      = r_q;
        r_d.rd_p = rd_s;
        r_d.wr_p = wr_s;
        unique case (r_q.st)
            S_IDLE: begin
                r_d.rdy = 1'b1;
                if (rd_rise) begin
                    unique case (sel)
                        SEL_EADDR, SEL_EDATA: begin
                            r_d.is_rd  = 1'b1;
                            r_d.is_adr = (sel == SEL_EADDR);
                            r_d.rdy    = 1'b0;
                            r_d.st     = S_WAIT_READY;
                        end
                        SEL_DATA: r_d.rdata = r_q.ctrl[CB_DIR] ? pd_in : r_q.data;
                        SEL_STAT: begin
                            r_d.rdata = {{(DW-1){1'b0}}, r_q.tmo};
                            r_d.tmo   = 1'b0;
                        end
                        SEL_CTRL: r_d.rdata = r_q.ctrl;
                        default:  r_d.rdata = '0;
                    endcase
                end else if (wr_rise) begin
                    unique case (sel)
                        SEL_EADDR, SEL_EDATA: begin
                            r_d.is_rd  = 1'b0;
                            r_d.is_adr = (sel == SEL_EADDR);
                            r_d.eout   = wdata;
                            r_d.rdy    = 1'b0;
                            r_d.st     = S_WAIT_READY;
                        end
                        SEL_DATA: r_d.data = wdata;
                        SEL_CTRL: r_d.ctrl = wdata;
                        default:  ;
                    endcase
                end
            end
            S_WAIT_READY: begin
                if (!host_act) begin
                    r_d.rdy = 1'b1;
                    r_d.st  = S_IDLE;
                end else if (!wait_s) begin
                    r_d.st = S_STROBE;
                end else if (expired) begin
                    r_d.st = S_ABORT;
                end
            end
            S_STROBE: begin
                if (!host_act) begin
                    r_d.rdy = 1'b1;
                    r_d.st  = S_IDLE;
                end else if (expired) begin
                    r_d.st = S_ABORT;
                end else begin
                    r_d.st = S_WAIT_DATA;
                end
            end
            S_WAIT_DATA: begin
                if (!host_act) begin
                    r_d.rdy = 1'b1;
                    r_d.st  = S_IDLE;
                end else if (wait_s) begin
                    r_d.rdy = 1'b1;
                    if (r_q.is_rd) r_d.rdata = pd_in;
                    r_d.st = S_TERMINATE;
                end else if (expired) begin
                    r_d.st = S_ABORT;
                end
            end
            S_TERMINATE, S_ABORT: begin
                if (!host_act) r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
        if (r_d.st == S_ABORT && r_q.st != S_ABORT) begin
            r_d.tmo = 1'b1;
            r_d.rdy = 1'b1;
            if (r_q.is_rd) r_d.rdata = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= S_IDLE;
            r_q.rdy  <= 1'b1;
            r_q.rd_p <= 1'b0;
            r_q.wr_p <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        init_n = ~r_q.ctrl[CB_INIT];
        stb_n  = ~r_q.ctrl[CB_STB];
        afd_n  = ~r_q.ctrl[CB_AFD];
        slin_n = ~r_q.ctrl[CB_SLIN];
        pd_oe  = ~r_q.ctrl[CB_DIR];
        pd_out = r_q.data;
        if (r_q.st == S_STROBE || r_q.st == S_WAIT_DATA ||
            r_q.st == S_TERMINATE || r_q.st == S_ABORT) begin
            stb_n  = r_q.is_rd;
            afd_n  = 1'b1;
            slin_n = 1'b1;
            pd_oe  = ~r_q.is_rd;
            pd_out = r_q.eout;
            if (r_q.st == S_WAIT_DATA || (r_q.st == S_TERMINATE && !r_q.is_rd)) begin
                if (r_q.is_adr) slin_n = 1'b0;
                else            afd_n  = 1'b0;
            end
        end
    end

    assign rdata = r_q.rdata;
    assign rdy   = r_q.rdy;

    p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == S_IDLE |-> rdy);

    p_hold_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT_READY && wait_s) |=> r_q.st != S_STROBE);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st != S_IDLE |-> (afd_n || slin_n));

    p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.is_rd && (r_q.st == S_STROBE || r_q.st == S_WAIT_DATA)) |-> !pd_oe);

    p_read_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT_DATA && r_q.is_rd && rd_s && wait_s)
        |=> (rdy && afd_n && slin_n));

    p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_TERMINATE && !r_q.is_rd) |-> (!afd_n || !slin_n) && !stb_n);

    p_abort_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == S_ABORT |-> (r_q.tmo && rdy && afd_n && slin_n));

    p_coincide_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_WAIT_DATA && host_act && wait_s && expired)
        |=> r_q.st == S_TERMINATE);

endmodule

// File: rtl/epp_cycle_ctrl.sv
module epp_cycle_ctrl #(
    parameter int CLK_KHZ     = 250000,
    parameter int TMO_US      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rd_n,
    input  logic       host_wr_n,
    input  logic [2:0] host_sel,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       host_rdy,
    input  logic [7:0] pd_in,
    output logic [7:0] pd_out,
    output logic       pd_oe,
    input  logic       pp_wait_n,
    output logic       pp_stb_n,
    output logic       pp_afd_n,
    output logic       pp_slin_n,
    output logic       pp_init_n
);

    localparam int TMO_CYC = (CLK_KHZ * TMO_US) / 1000;

    logic [2:0] raw_n, syn_n;
    logic       run, expired;

    assign raw_n = {pp_wait_n, host_wr_n, host_rd_n};

    epp_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_n),
        .dout (syn_n)
    );

    epp_wdog #(.LIMIT(TMO_CYC)) u_wdog (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .expired(expired)
    );

    epp_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_s   (~syn_n[0]),
        .wr_s   (~syn_n[1]),
        .wait_s (syn_n[2]),
        .sel    (host_sel),
        .wdata  (host_wdata),
        .pd_in  (pd_in),
        .expired(expired),
        .run    (run),
        .rdata  (host_rdata),
        .rdy    (host_rdy),
        .pd_out (pd_out),
        .pd_oe  (pd_oe),
        .stb_n  (pp_stb_n),
        .afd_n  (pp_afd_n),
        .slin_n (pp_slin_n),
        .init_n (pp_init_n)
    );

endmodule

// File: tb/sim_epp_cycle_ctrl.sv
module sim_epp_cycle_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic [2:0] host_sel = 3'd0;
    logic [7:0] host_wdata = 8'd0;
    logic [7:0] host_rdata;
    logic       host_rdy;
    logic [7:0] pd_in, pd_out;
    logic       pd_oe;
    logic       pp_wait_n = 1'b0;
    logic       pp_stb_n, pp_afd_n, pp_slin_n, pp_init_n;

    int n_run = 0, n_fail = 0;

    logic [7:0] per_val = 8'h00;
    int         per_delay = 0, per_cnt = 0;
    bit         per_stall = 0, per_busy = 0, per_on = 0;
    logic [7:0] cap_val;
    bit         cap_oe, cap_wr_n, cap_adr, cap_seen;

    assign pd_in = per_val;

    always #2 clk = ~clk;

    epp_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rdy(host_rdy), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
        .pp_wait_n(pp_wait_n), .pp_stb_n(pp_stb_n), .pp_afd_n(pp_afd_n),
        .pp_slin_n(pp_slin_n), .pp_init_n(pp_init_n)
    );

    // peripheral model: answers a strobe after per_delay cycles unless stalled
    always @(negedge clk) begin
        if (per_on && (!pp_afd_n || !pp_slin_n)) begin
            if (!per_stall && !pp_wait_n) begin
                if (per_cnt >= per_delay) begin
                    pp_wait_n <= 1'b1;
                    cap_val   <= pd_out;
                    cap_oe    <= pd_oe;
                    cap_wr_n  <= pp_stb_n;
                    cap_adr   <= !pp_slin_n;
                    cap_seen  <= 1'b1;
                end else begin
                    per_cnt <= per_cnt + 1;
                end
            end
        end else begin
            pp_wait_n <= per_busy;
            per_cnt   <= 0;
        end
    end

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] f_pins(input logic [7:0] c);
        return {~c[0], ~c[1], ~c[3], ~c[2], ~c[5]};
    endfunction

    // one host access; returns data, whether rdy went low, and strobes at completion
    task automatic host_op(input logic [2:0] sel, input bit rd, input logic [7:0] wd,
                           output logic [7:0] rdv, output bit stretched,
                           output logic afd_at_end, output logic slin_at_end);
        @(negedge clk);
        host_sel   = sel;
        host_wdata = wd;
        cap_seen   = 0;
        if (rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        stretched = !host_rdy;
        for (int i = 0; i < 8000 && !host_rdy; i++) @(negedge clk);
        @(negedge clk);
        rdv         = host_rdata;
        afd_at_end  = pp_afd_n;
        slin_at_end = pp_slin_n;
        host_rd_n = 1'b1;
        host_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv, wd, ctl, exp_rd;
        bit         st, got_ok, got_abort;
        logic       ae, se;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(host_rdy == 1'b1, "R1 rdy", host_rdy, 1);
        chk({pp_stb_n, pp_afd_n, pp_slin_n, pp_init_n, pd_oe} == 5'b11111, "R1 pins",
            {pp_stb_n, pp_afd_n, pp_slin_n, pp_init_n, pd_oe}, 5'b11111);
        chk(pd_out == 8'h00, "R1 pd_out", pd_out, 0);
        host_op(3'd1, 1, 8'h00, rv, st, ae, se);
        chk(rv == 8'h00, "R1 status", rv, 0);
        chk(!st, "R2 status no stretch", st, 0);

        // R8 / R9 idle mapping under several control values
        for (int k = 0; k < 6; k++) begin
            ctl = 8'($urandom);
            host_op(3'd2, 0, ctl, rv, st, ae, se);
            chk({pp_stb_n, pp_afd_n, pp_slin_n, pp_init_n, pd_oe} == f_pins(ctl), "R8 pin map",
                {pp_stb_n, pp_afd_n, pp_slin_n, pp_init_n, pd_oe}, f_pins(ctl));
            host_op(3'd2, 1, 8'h00, rv, st, ae, se);
            chk(rv == ctl, "R8 ctrl readback", rv, ctl);
            wd = 8'($urandom);
            per_val = 8'($urandom);
            host_op(3'd0, 0, wd, rv, st, ae, se);
            chk(pd_out == wd, "R9 pd_out", pd_out, wd);
            host_op(3'd0, 1, 8'h00, rv, st, ae, se);
            exp_rd = ctl[5] ? per_val : wd;
            chk(rv == exp_rd, "R9 data read", rv, exp_rd);
        end

        // R10 unused selects
        host_op(3'd2, 0, 8'h00, rv, st, ae, se);
        host_op(3'd0, 0, 8'h5A, rv, st, ae, se);
        for (int s = 5; s < 8; s++) begin
            host_op(3'(s), 0, 8'hFF, rv, st, ae, se);
            chk({pp_stb_n, pp_afd_n, pp_slin_n, pp_init_n, pd_oe} == 5'b11111 && pd_out == 8'h5A,
                "R10 pins untouched", pd_out, 8'h5A);
            host_op(3'd2, 1, 8'h00, rv, st, ae, se);
            chk(rv == 8'h00, "R10 ctrl untouched", rv, 0);
            host_op(3'(s), 1, 8'h00, rv, st, ae, se);
            chk(rv == 8'h00 && !st, "R10 read zero", rv, 0);
        end

        per_on = 1;

        // R3 peripheral busy: no strobe, no direction change, rdy held
        per_busy = 1;
        per_delay = 2;
        per_val = 8'h3C;
        @(negedge clk);
        host_sel = 3'd4;
        host_rd_n = 1'b0;
        repeat (30) @(negedge clk);
        chk(pp_afd_n && pp_slin_n && pp_stb_n, "R3 no strobe while busy",
            {pp_afd_n, pp_slin_n, pp_stb_n}, 3'b111);
        chk(!host_rdy, "R3 rdy held low", host_rdy, 0);
        per_busy = 0;
        for (int i = 0; i < 100 && !host_rdy; i++) @(negedge clk);
        @(negedge clk);
        chk(host_rdata == 8'h3C, "R3 read after ready", host_rdata, 8'h3C);
        host_rd_n = 1'b1;
        repeat (5) @(negedge clk);

        // R4 / R5 random EPP traffic
        for (int k = 0; k < 40; k++) begin
            bit rd, adr;
            rd = 1'($urandom);
            adr = 1'($urandom);
            per_delay = int'($urandom % 30);
            per_val = 8'($urandom & 8'h7F);
            wd = 8'($urandom);
            host_op(adr ? 3'd3 : 3'd4, rd, wd, rv, st, ae, se);
            chk(st, "R2 EPP stretch", st, 1);
            chk(cap_adr == adr, "R4/R5 strobe select", cap_adr, adr);
            if (rd) begin
                chk(rv == per_val, "R4 read data", rv, per_val);
                chk(!cap_oe && cap_wr_n, "R4 bus released, dir high", {cap_oe, cap_wr_n}, 2'b01);
                chk(ae && se, "R4 strobe released", {ae, se}, 2'b11);
            end else begin
                chk(cap_val == wd, "R5 write data", cap_val, wd);
                chk(cap_oe && !cap_wr_n, "R5 bus driven, dir low", {cap_oe, cap_wr_n}, 2'b10);
                chk(adr ? !se : !ae, "R5 strobe held until release", {ae, se}, adr ? 2'b10 : 2'b01);
            end
        end
        host_op(3'd1, 1, 8'h00, rv, st, ae, se);
        chk(rv == 8'h00, "R7 no spurious timeout", rv, 0);

        // R6 stalled write and read
        per_stall = 1;
        host_op(3'd4, 0, 8'hA5, rv, st, ae, se);
        chk(ae && se, "R6 strobes released on abort", {ae, se}, 2'b11);
        host_op(3'd3, 1, 8'h00, rv, st, ae, se);
        chk(rv == 8'hFF, "R6 aborted read value", rv, 8'hFF);
        host_op(3'd1, 1, 8'h00, rv, st, ae, se);
        chk(rv == 8'h01, "R6/R7 status flag", rv, 1);
        host_op(3'd1, 1, 8'h00, rv, st, ae, se);
        chk(rv == 8'h00, "R7 flag cleared", rv, 0);
        per_stall = 0;

        // R11 sweep response delay across the timeout boundary
        got_ok = 0;
        got_abort = 0;
        for (int d = 2486; d < 2506; d++) begin
            per_delay = d;
            per_val = 8'(d & 8'h7F);
            host_op(3'd4, 1, 8'h00, rv, st, ae, se);
            exp_rd = per_val;
            host_op(3'd1, 1, 8'h00, wd, st, ae, se);
            if (wd[0]) got_abort = 1; else got_ok = 1;
            chk((wd == 8'h01 && rv == 8'hFF) || (wd == 8'h00 && rv == exp_rd),
                "R11 coherent outcome", {wd, rv}, {8'h00, exp_rd});
        end
        chk(got_ok && got_abort, "R11 both outcomes seen", {got_ok, got_abort}, 2'b11);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule